// File: doc/BRIEF.md
# Masked Time Alarm Interrupt Controller

This block watches a running clock/calendar and raises interrupts when the time reaches one of two programmed alarm points. The time keeper outside it supplies the current seconds, minutes, hours, day-of-week and day-of-month as BCD bytes, plus a one-cycle strobe each time those bytes advance. The block compares the new time against two alarm register sets. The first set has bytes for seconds, minutes, hours and day/date. The second set has no seconds byte. It keeps a sticky flag per alarm and drives two active-low interrupt pins.

Every alarm byte carries a mask bit in bit 7 that removes it from the comparison. The repeat rate therefore runs from every second (first alarm) or every minute (second alarm) up to a full day-or-date match. A control byte holds the per-alarm enables, a routing bit, the square-wave rate and an oscillator-stop request. A status byte holds the two alarm flags and an oscillator-stop flag. Software can clear these flags but can never set them.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After reset the control byte reads 0x18, the status byte reads 0x80, both interrupt pins are high, the rate output is 2'b11 and sqw_on is 1.
- R2: Register select values 0..3 write the first alarm's seconds, minutes, hours and day/date bytes. A write to one of these bytes takes effect at the clock edge of the write. In each of these bytes, bit 7 = 1 masks the byte out of the comparison. An unmasked seconds, minutes or hours byte matches when its bits 6:0 equal bits 6:0 of the matching time byte. With all four bytes masked, the alarm matches on every update strobe.
- R3: In a day/date alarm byte, bit 6 = 1 compares bits 5:0 with the day-of-week input, and bit 6 = 0 compares them with the day-of-month input.
- R4: Select values 4..6 write the second alarm's minutes, hours and day/date bytes. The second alarm can only match when the seconds input equals 0x00, even when all its bytes are masked.
- R5: A match sets its flag (status bit 0 for the first alarm, bit 1 for the second) at the clock edge where tick_sec is 1. With tick_sec at 0, matching time inputs change no flag.
- R6: Select value 8 writes the status byte. Writing 0 to a flag bit clears it. Writing 1 leaves it unchanged. When a match and a clearing write occur in the same cycle, the flag ends up set.
- R7: Select value 7 writes the control byte: bit 0 enables the first alarm, bit 1 enables the second, bit 2 selects routing. With bit 2 = 0, irq_a_n is low while either enabled flag is set, irq_b_n stays high and sqw_on is 1.
- R8: With control bit 2 = 1, irq_a_n follows only the enabled first-alarm flag, irq_b_n follows only the enabled second-alarm flag, and sqw_on is 0.
- R9: sqw_rate equals control bits 4:3 (00 = 1 Hz, 01 = 4.096 kHz, 10 = 8.192 kHz, 11 = 32.768 kHz).
- R10: Status bit 7 is set by reset and is set on every clock edge while control bit 7 is 1. A status write with bit 7 = 0 clears it only if control bit 7 is 0 at that edge.
- R11: Control bits 6:5 and status bits 6:2 always read 0, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_sec | input | 1 | One-cycle strobe: the time bytes hold a newly updated time |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours byte (12/24 and AM/PM bits included) |
| now_wday | input | 8 | Current day of week |
| now_mday | input | 8 | Current day of month, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select (0..8) |
| wr_data | input | 8 | Register write data |
| ctrl_byte | output | 8 | Current control byte |
| status_byte | output | 8 | Current status byte |
| irq_a_n | output | 1 | First interrupt pin, active low |
| irq_b_n | output | 1 | Second interrupt pin, active low |
| sqw_on | output | 1 | 1 when the second pin is given to the square wave |
| sqw_rate | output | 2 | Selected square-wave rate code |

## Verification
A wrong flag value shows up in the status byte on the clock edge after the strobe or write that caused it. When that alarm is enabled, the same error reaches an interrupt pin with no further delay. A wrong stored alarm byte stays hidden until a strobe arrives whose time separates the correct comparison from the wrong one. For that reason the stimulus uses time values one step on each side of every alarm point, and it tries both settings of the day/date select. A routing error shows up only when a flag is set, so each routing mode is checked while each flag in turn is set.

// File: rtl/alarm_irq_pkg.sv
// Shared types, register selects and bit positions for the alarm controller.
package alarm_irq_pkg;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 4;

    typedef logic [BYTE_W-1:0] byte_t;

    // Register select values (software map of this block)
    localparam logic [SEL_W-1:0] SEL_A1_SEC  = 4'd0;
    localparam logic [SEL_W-1:0] SEL_A1_MIN  = 4'd1;
    localparam logic [SEL_W-1:0] SEL_A1_HOUR = 4'd2;
    localparam logic [SEL_W-1:0] SEL_A1_DD   = 4'd3;
    localparam logic [SEL_W-1:0] SEL_A2_MIN  = 4'd4;
    localparam logic [SEL_W-1:0] SEL_A2_HOUR = 4'd5;
    localparam logic [SEL_W-1:0] SEL_A2_DD   = 4'd6;
    localparam logic [SEL_W-1:0] SEL_CTRL    = 4'd7;
    localparam logic [SEL_W-1:0] SEL_STAT    = 4'd8;

    // Alarm byte fields
    localparam int MASK_BIT = 7;
    localparam int DYDT_BIT = 6;

    // Control byte fields
    localparam int CTL_STOP  = 7;
    localparam int CTL_RATE  = 3;   // two bits, 4:3
    localparam int CTL_ROUTE = 2;

    // Status byte fields
    localparam int ST_OSF = 7;

    localparam byte_t CTRL_RESET = 8'h18;
    localparam byte_t CTRL_KEEP  = 8'h9F;

    typedef struct packed {
        byte_t sec;
        byte_t min;
        byte_t hour;
        byte_t dd;
    } alarm_t;

    typedef struct packed {
        byte_t sec;
        byte_t min;
        byte_t hour;
        byte_t wday;
        byte_t mday;
    } now_t;
endpackage

// File: rtl/alarm_regs.sv
// Alarm and control register storage.
// Holds both alarm register sets and the control byte and updates them
// from the shared write port. The status byte is not stored here.
// Assumes: wr_sel is meaningful only while wr_en is 1.
module alarm_regs
    import alarm_irq_pkg::*;
#(
    parameter int NUM_ALARMS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  byte_t            wr_data,
    output alarm_t           alarms [NUM_ALARMS],
    output byte_t            ctrl_q
);
    localparam int A2_BASE = 4;

    byte_t a1_q [4];
    byte_t a2_q [3];

    // Store the first alarm set, one byte per select value 0..3
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) a1_q[i] <= '0;
        end else if (wr_en && (wr_sel < SEL_W'(4))) begin
            a1_q[wr_sel[1:0]] <= wr_data;
        end
    end

    // Store the second alarm set, select values 4..6
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) a2_q[i] <= '0;
        end else if (wr_en && (wr_sel >= SEL_A2_MIN) && (wr_sel <= SEL_A2_DD)) begin
            a2_q[int'(wr_sel) - A2_BASE] <= wr_data;
        end
    end

    // Store the control byte, spare bits forced to zero
    always_ff @(posedge clk) begin
        if (!rst_n)                           ctrl_q <= CTRL_RESET;
        else if (wr_en && wr_sel == SEL_CTRL) ctrl_q <= wr_data & CTRL_KEEP;
    end

    // Present the stored bytes as alarm structures
    always_comb begin
        for (int k = 0; k < NUM_ALARMS; k++) alarms[k] = '0;
        alarms[0] = '{sec: a1_q[0], min: a1_q[1], hour: a1_q[2], dd: a1_q[3]};
        alarms[1] = '{sec: 8'h80, min: a2_q[0], hour: a2_q[1], dd: a2_q[2]};
    end

    // R9: the rate field follows the last control write
    a_r9_rate_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CTRL) |=> (ctrl_q[CTL_RATE+:2] == $past(wr_data[CTL_RATE+:2])));
endmodule

// File: rtl/alarm_match.sv
// Compares the updated time with one alarm register set.
// HAS_SEC = 0 builds an alarm without a seconds byte; such an alarm can
// match only at seconds 00. Purely combinational.
// Assumes: only the documented mask combinations are meaningful.
module alarm_match
    import alarm_irq_pkg::*;
#(
    parameter bit HAS_SEC = 1'b1
) (
    input  alarm_t cfg,
    input  now_t   now,
    output logic   hit
);
    logic sec_ok, min_ok, hour_ok, dd_ok;
    byte_t dd_target;

    // Seconds term: masked compare, or fixed zero-second for alarm without seconds byte
    generate
        if (HAS_SEC) begin : g_sec
            assign sec_ok = cfg.sec[MASK_BIT] || (cfg.sec[6:0] == now.sec[6:0]);
        end else begin : g_nosec
            assign sec_ok = (now.sec == 8'h00);
        end
    endgenerate

    // Minutes and hours terms: unmasked bytes compare bits 6:0
    always_comb begin
        min_ok  = cfg.min[MASK_BIT]  || (cfg.min[6:0]  == now.min[6:0]);
        hour_ok = cfg.hour[MASK_BIT] || (cfg.hour[6:0] == now.hour[6:0]);
    end

    // Day/date term: bit 6 picks day-of-week or day-of-month
    always_comb begin
        dd_target = cfg.dd[DYDT_BIT] ? now.wday : now.mday;
        dd_ok     = cfg.dd[MASK_BIT] || (cfg.dd[5:0] == dd_target[5:0]);
    end

    assign hit = sec_ok && min_ok && hour_ok && dd_ok;
endmodule

// File: rtl/alarm_status.sv
// Sticky alarm flags and oscillator-stop flag.
// A flag sets on a match at an update strobe. A status write clears a flag
// only where the written bit is 0. A set in the same cycle wins over a clear.
// Assumes: stat_wr is one cycle per write.
module alarm_status
    import alarm_irq_pkg::*;
#(
    parameter int NUM_ALARMS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic [NUM_ALARMS-1:0] hit,
    input  logic                  stat_wr,
    input  byte_t                 wr_data,
    input  logic                  stop_osc,
    output logic [NUM_ALARMS-1:0] flags_q,
    output logic                  osf_q
);
    // Update each alarm flag: set on strobed match, clear on written zero
    generate
        for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_flag
            always_ff @(posedge clk) begin
                if (!rst_n) flags_q[g] <= 1'b0;
                else        flags_q[g] <= (tick && hit[g]) ||
                                          (flags_q[g] && !(stat_wr && !wr_data[g]));
            end

            // R5: a flag rises only at an update strobe
            a_r5_flag_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(flags_q[g]) |-> $past(tick));

            // R6: writing a one never sets a clear flag
            a_r6_one_write_keeps_clear: assert property (@(posedge clk) disable iff (!rst_n)
                (stat_wr && wr_data[g] && !flags_q[g] && !tick) |=> !flags_q[g]);
        end
    endgenerate

    // Oscillator-stop flag: set by reset or stop request, clear on written zero
    always_ff @(posedge clk) begin
        if (!rst_n) osf_q <= 1'b1;
        else        osf_q <= stop_osc || (osf_q && !(stat_wr && !wr_data[ST_OSF]));
    end

    // R10: a stop request always leaves the flag set
    a_r10_osf_follows_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_osc |=> osf_q);
endmodule

// File: rtl/alarm_irq_ctrl.sv
// Masked time alarm interrupt controller, top level.
// Compares the time bytes with two alarm sets on each update strobe,
// keeps sticky flags and routes them to two active-low interrupt pins.
// Also exports the square-wave rate code.
// Assumes: the time bytes are stable and valid in the strobe cycle.
module alarm_irq_ctrl
    import alarm_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_sec,
    input  logic [7:0] now_sec,
    input  logic [7:0] now_min,
    input  logic [7:0] now_hour,
    input  logic [7:0] now_wday,
    input  logic [7:0] now_mday,
    input  logic       wr_en,
    input  logic [3:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] ctrl_byte,
    output logic [7:0] status_byte,
    output logic       irq_a_n,
    output logic       irq_b_n,
    output logic       sqw_on,
    output logic [1:0] sqw_rate
);
    localparam int NUM_ALARMS = 2;

    alarm_t                cfg [NUM_ALARMS];
    byte_t                 ctrl_q;
    now_t                  now;
    logic [NUM_ALARMS-1:0] hit;
    logic [NUM_ALARMS-1:0] flags_q;
    logic                  osf_q;
    logic [NUM_ALARMS-1:0] active;
    logic                  route_split;

    assign now = '{sec: now_sec, min: now_min, hour: now_hour, wday: now_wday, mday: now_mday};

    alarm_regs #(.NUM_ALARMS(NUM_ALARMS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .alarms  (cfg),
        .ctrl_q  (ctrl_q)
    );

    // One comparator per alarm; only the first has a seconds byte
    generate
        for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_match
            alarm_match #(.HAS_SEC(g == 0)) u_match (
                .cfg (cfg[g]),
                .now (now),
                .hit (hit[g])
            );
        end
    endgenerate

    alarm_status #(.NUM_ALARMS(NUM_ALARMS)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_sec),
        .hit      (hit),
        .stat_wr  (wr_en && wr_sel == SEL_STAT),
        .wr_data  (wr_data),
        .stop_osc (ctrl_q[CTL_STOP]),
        .flags_q  (flags_q),
        .osf_q    (osf_q)
    );

    // Route enabled flags to the interrupt pins
    always_comb begin
        active      = flags_q & ctrl_q[NUM_ALARMS-1:0];
        route_split = ctrl_q[CTL_ROUTE];
        irq_a_n     = !(active[0] || (active[1] && !route_split));
        irq_b_n     = !(active[1] && route_split);
        sqw_on      = !route_split;
        sqw_rate    = ctrl_q[CTL_RATE+:2];
        ctrl_byte   = ctrl_q;
        status_byte = {osf_q, 5'b0, flags_q};
    end

    // R7: with no flag set both pins idle high
    a_r7_idle_pins_high: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[1:0] == 2'b00) |-> (irq_a_n && irq_b_n));

    // R8: the second pin asserts only in split routing
    a_r8_b_pin_needs_split: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_b_n |-> ctrl_byte[CTL_ROUTE]);
endmodule

// File: tb/alarm_irq_ctrl_bench.sv
module alarm_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_sec = 1'b0;
    logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_wday = '0, now_mday = '0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] ctrl_byte, status_byte;
    logic       irq_a_n, irq_b_n, sqw_on;
    logic [1:0] sqw_rate;

    always #10 clk = ~clk;

    alarm_irq_ctrl u_alarm_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_sec(tick_sec),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .now_wday(now_wday), .now_mday(now_mday),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ctrl_byte(ctrl_byte), .status_byte(status_byte),
        .irq_a_n(irq_a_n), .irq_b_n(irq_b_n), .sqw_on(sqw_on), .sqw_rate(sqw_rate)
    );

    typedef struct packed {
        logic       ia;
        logic       ib;
        logic       sq;
        logic [1:0] rt;
        logic [7:0] ct;
        logic [7:0] st;
    } obs_t;

    obs_t  exp_q[$];
    string tag_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;

    // Bench model of the register state, from the requirements
    logic [7:0] m_al [7];
    logic [7:0] m_ctrl;
    logic [7:0] m_stat;

    function automatic logic byte_ok(input logic [7:0] a, input logic [7:0] t);
        return a[7] || (a[6:0] == t[6:0]);
    endfunction

    function automatic logic dd_ok(input logic [7:0] a, input logic [7:0] wd, input logic [7:0] md);
        if (a[7]) return 1'b1;
        return a[6] ? (a[5:0] == wd[5:0]) : (a[5:0] == md[5:0]);
    endfunction

    function automatic obs_t model_obs();
        obs_t o;
        logic e1, e2;
        e1 = m_stat[0] && m_ctrl[0];
        e2 = m_stat[1] && m_ctrl[1];
        o.ia = !(e1 || (e2 && !m_ctrl[2]));
        o.ib = !(e2 && m_ctrl[2]);
        o.sq = !m_ctrl[2];
        o.rt = m_ctrl[4:3];
        o.ct = m_ctrl;
        o.st = m_stat;
        return o;
    endfunction

    // Driver: applies one cycle of stimulus and pushes the expected result
    task automatic step(input string tag, input bit tk,
                        input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                        input logic [7:0] wd, input logic [7:0] md,
                        input bit we, input logic [3:0] sel, input logic [7:0] d);
        logic h1, h2;
        logic [7:0] clr;
        @(negedge clk);
        tick_sec = tk; now_sec = s; now_min = mi; now_hour = h; now_wday = wd; now_mday = md;
        wr_en = we; wr_sel = sel; wr_data = d;
        h1 = tk && byte_ok(m_al[0], s) && byte_ok(m_al[1], mi) && byte_ok(m_al[2], h) && dd_ok(m_al[3], wd, md);
        h2 = tk && (s == 8'h00) && byte_ok(m_al[4], mi) && byte_ok(m_al[5], h) && dd_ok(m_al[6], wd, md);
        clr = (we && sel == 4'd8) ? ~d : 8'h00;
        m_stat[0] = h1 || (m_stat[0] && !clr[0]);
        m_stat[1] = h2 || (m_stat[1] && !clr[1]);
        m_stat[7] = m_ctrl[7] || (m_stat[7] && !clr[7]);
        if (we && sel < 4'd7) m_al[sel] = d;
        if (we && sel == 4'd7) m_ctrl = d & 8'h9F;
        @(posedge clk);
        #1;
        tick_sec = 1'b0; wr_en = 1'b0;
        exp_q.push_back(model_obs());
        tag_q.push_back(tag);
    endtask

    task automatic wr(input string tag, input logic [3:0] sel, input logic [7:0] d);
        step(tag, 0, now_sec, now_min, now_hour, now_wday, now_mday, 1, sel, d);
    endtask

    task automatic tk(input string tag, input logic [7:0] s, input logic [7:0] mi,
                      input logic [7:0] h, input logic [7:0] wd, input logic [7:0] md);
        step(tag, 1, s, mi, h, wd, md, 0, 4'd0, 8'h00);
    endtask

    // Monitor: compares each expected item with the ports away from the edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            obs_t  e, a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = '{ia: irq_a_n, ib: irq_b_n, sq: sqw_on, rt: sqw_rate, ct: ctrl_byte, st: status_byte};
            n_cmp++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s: actual ia=%b ib=%b sq=%b rt=%b ct=%h st=%h expected ia=%b ib=%b sq=%b rt=%b ct=%h st=%h",
                         t, a.ia, a.ib, a.sq, a.rt, a.ct, a.st, e.ia, e.ib, e.sq, e.rt, e.ct, e.st);
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 7; i++) m_al[i] = 8'h00;
        m_ctrl = 8'h18;
        m_stat = 8'h80;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state
        exp_q.push_back(model_obs()); tag_q.push_back("R1");
        @(negedge clk);

        // R10: clear the oscillator-stop flag; R11 spare bits stay zero
        wr("R10", 4'd8, 8'h7C);
        // R7 R9 R11: enables on, shared routing, rate 01, spare bits written 1
        wr("R9", 4'd7, 8'h6B);
        // R2: first alarm hh:mm:ss = 08:15:30, day/date masked
        wr("R2", 4'd0, 8'h30);
        wr("R2", 4'd1, 8'h15);
        wr("R2", 4'd2, 8'h08);
        wr("R2", 4'd3, 8'h80);
        // R2: one second early, no match
        tk("R2", 8'h29, 8'h15, 8'h08, 8'h02, 8'h11);
        // R5: matching time without a strobe
        step("R5", 0, 8'h30, 8'h15, 8'h08, 8'h02, 8'h11, 0, 4'd0, 8'h00);
        // R2 R7: matching time with a strobe, pin A low
        tk("R2", 8'h30, 8'h15, 8'h08, 8'h02, 8'h11);
        // R6: write ones, flag unchanged
        wr("R6", 4'd8, 8'hFF);
        // R6: write zero to bit 0, flag clears
        wr("R6", 4'd8, 8'h02);
        // R2: hour off by one, no match
        tk("R2", 8'h30, 8'h15, 8'h09, 8'h02, 8'h11);

        // R4: second alarm all masked
        wr("R4", 4'd4, 8'h80);
        wr("R4", 4'd5, 8'h80);
        wr("R4", 4'd6, 8'h80);
        tk("R4", 8'h01, 8'h16, 8'h08, 8'h02, 8'h11);
        tk("R4", 8'h59, 8'h16, 8'h08, 8'h02, 8'h11);
        // R4 R7: seconds 00, second alarm fires on pin A
        tk("R4", 8'h00, 8'h17, 8'h08, 8'h02, 8'h11);
        // R8: split routing moves it to pin B
        wr("R8", 4'd7, 8'h07);
        // R8: first alarm flag set too, pin A from first alarm only
        tk("R8", 8'h30, 8'h15, 8'h08, 8'h02, 8'h11);
        // R8: disable second alarm, pin B releases
        wr("R8", 4'd7, 8'h05);
        // R9: rate 10 and 00
        wr("R9", 4'd7, 8'h10);
        wr("R9", 4'd7, 8'h00);
        wr("R6", 4'd8, 8'h00);

        // R3: first alarm 12:20:10 on day-of-week 5
        wr("R3", 4'd0, 8'h10);
        wr("R3", 4'd1, 8'h20);
        wr("R3", 4'd2, 8'h12);
        wr("R3", 4'd3, 8'h45);
        wr("R3", 4'd7, 8'h01);
        tk("R3", 8'h10, 8'h20, 8'h12, 8'h04, 8'h05);
        tk("R3", 8'h10, 8'h20, 8'h12, 8'h05, 8'h17);
        wr("R3", 4'd8, 8'h00);
        // R3: same alarm on day-of-month 5
        wr("R3", 4'd3, 8'h05);
        tk("R3", 8'h10, 8'h20, 8'h12, 8'h05, 8'h17);
        tk("R3", 8'h10, 8'h20, 8'h12, 8'h04, 8'h05);

        // R6: match and clear in the same cycle, set wins
        step("R6", 1, 8'h10, 8'h20, 8'h12, 8'h04, 8'h05, 1, 4'd8, 8'h00);
        wr("R6", 4'd8, 8'h00);

        // R2: all four bytes masked, fires every strobe
        wr("R2", 4'd0, 8'h80);
        wr("R2", 4'd1, 8'h80);
        wr("R2", 4'd2, 8'h80);
        wr("R2", 4'd3, 8'h80);
        tk("R2", 8'h42, 8'h33, 8'h21, 8'h01, 8'h09);
        wr("R2", 4'd8, 8'h00);
        tk("R2", 8'h43, 8'h33, 8'h21, 8'h01, 8'h09);

        // R10: stop request sets the flag and blocks a clear
        wr("R10", 4'd7, 8'h80);
        wr("R10", 4'd8, 8'h00);
        wr("R10", 4'd7, 8'h18);
        wr("R10", 4'd8, 8'hFF);
        wr("R10", 4'd8, 8'h00);
        // R11: spare status bits read zero after ones written
        wr("R11", 4'd8, 8'h7C);

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule